// File: doc/BRIEF.md
# Audio DAC Control Sequencer

This block brings up and then drives an external audio converter through a byte-level I2C master. After reset it probes two candidate device addresses. It keeps the first one that answers. Then it plays a fixed start-up script of register writes. From then on it serves one-hot command requests: make active, go to standby, power down, switch the analogue output stage on, or switch it off.

Every register write is a single bus transaction. Switching the analogue stage is a compound operation. The block first parks the converter in standby and then waits a programmable number of milliseconds. After that it changes the analogue-stage register and returns the converter to active. The pause is counted in clock cycles, from a cycles-per-millisecond parameter. The bit-level I2C engine sits outside this block. The block hands that engine one operation at a time (start, write byte, read byte, stop) and receives a completion pulse with the acknowledge status.

Top module: `dacctl_seq`

## Requirements
- R1: After reset the block probes address 0x90 first and 0x98 second. Each probe is the operation sequence START, WRITE {addr[7:1],0}, WRITE 0x00, START, WRITE {addr[7:1],1}, READ, STOP. The first probe with no NACK sets `dev_addr_o` to that address, and no further probe follows.
- R2: If both probes get a NACK, `dev_addr_o` stays 0x00 and `error_o` goes high one cycle after the second probe's STOP completes. No start-up writes are issued, and `busy_o` falls in that same cycle.
- R3: A register write is START, WRITE {addr[7:1],0}, WRITE register index, WRITE value, STOP.
- R4: After a successful probe the start-up writes go out in this order: 0x00←0x00, 0x02←0x10, 0x0D←0x10, 0x25←0x08, 0x02←0x00.
- R5: The command request bits map to these writes: bit0 is active (0x02←0x00), bit1 is standby (0x02←0x10), bit2 is power-down (0x02←0x01).
- R6: Bit3 (analogue on) and bit4 (analogue off) each produce a standby write, then a pause, then 0x2E←0x01 (on) or 0x2E←0x00 (off), then an active write. The gap from the standby STOP completion to the next START is at least PAUSE_MS×CYC_PER_MS cycles and at most 4 cycles more.
- R7: A request is taken only when `busy_o` is low and exactly one request bit is set. `cmd_ack_o` then pulses for one cycle, in the cycle after the request is sampled. A request with several bits set, or one made while busy, gets no ack and causes no bus operation.
- R8: `busy_o` is high through reset and start-up. It is also high from a request's acceptance until two cycles after the STOP of its last write completes. At all other times it is low, and while it is low no operation is presented.
- R9: A NACK on any written byte aborts the transaction: STOP is the next operation. `error_o` rises one cycle after that STOP completes and stays high until reset. The rest of the script still runs.
- R10: An operation (code 0 START, 1 WRITE, 2 READ, 3 STOP) and its byte stay stable while `i2c_op_valid_o` is high until `i2c_done_i` pulses. Each completion pulse advances exactly one operation.
- R11: During reset `busy_o` is 1, and `error_o`, `cmd_ack_o`, `dev_addr_o` and `i2c_op_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_req_i | input | 5 | One-hot command request |
| cmd_ack_o | output | 1 | One-cycle acceptance pulse |
| busy_o | output | 1 | Sequence in progress |
| error_o | output | 1 | Sticky NACK / no-device flag |
| dev_addr_o | output | 8 | Discovered device address (0 if none) |
| i2c_op_valid_o | output | 1 | Byte-level operation presented |
| i2c_op_o | output | 2 | Operation code |
| i2c_byte_o | output | 8 | Byte to write |
| i2c_done_i | input | 1 | Operation complete pulse |
| i2c_nack_i | input | 1 | NACK status, valid with done |

## Verification
The bench sets CYC_PER_MS to 20 while keeping a 50 ms pause. The analogue switch wait therefore shrinks to 1000 cycles, so several compound commands fit in one short run, and the exact pause window can still be measured. The bench's device model is reset three times: answering at the second address, answering at the first, and absent. One run also plants a register that refuses writes. Together these cover probe fall-through, probe skip, total discovery failure and the mid-transaction abort.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

    localparam int NUM_CMDS = 5;
    localparam int PTR_W    = 5;
    localparam logic [7:0] TABLE_END = 8'hFF;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } i2c_op_e;

    typedef enum logic [1:0] {
        SQ_PROBE,
        SQ_RUN,
        SQ_WAIT,
        SQ_IDLE
    } seq_state_e;

    typedef struct packed {
        logic       pause;
        logic [7:0] ridx;
        logic [7:0] val;
    } seq_step_t;

    // First script slot of each command, indexed by request bit
    function automatic logic [PTR_W-1:0] cmd_entry(input int idx);
        case (idx)
            0:       return 5'd6;
            1:       return 5'd8;
            2:       return 5'd10;
            3:       return 5'd12;
            default: return 5'd17;
        endcase
    endfunction

endpackage

// File: rtl/dacctl_script.sv
module dacctl_script
    import dacctl_pkg::*;
(
    input  logic [PTR_W-1:0] ptr_i,
    output seq_step_t        step_o
);

    function automatic seq_step_t wr(input logic [7:0] r, input logic [7:0] v);
        return '{pause: 1'b0, ridx: r, val: v};
    endfunction

    localparam seq_step_t PAUSE_STEP = '{pause: 1'b1, ridx: TABLE_END, val: 8'h00};

    always_comb begin
        case (ptr_i)
            // start-up script
            5'd0:  step_o = wr(8'h00, 8'h00);
            5'd1:  step_o = wr(8'h02, 8'h10);
            5'd2:  step_o = wr(8'h0D, 8'h10);
            5'd3:  step_o = wr(8'h25, 8'h08);
            5'd4:  step_o = wr(8'h02, 8'h00);
            // active
            5'd6:  step_o = wr(8'h02, 8'h00);
            // standby
            5'd8:  step_o = wr(8'h02, 8'h10);
            // power-down
            5'd10: step_o = wr(8'h02, 8'h01);
            // analogue on
            5'd12: step_o = wr(8'h02, 8'h10);
            5'd13: step_o = PAUSE_STEP;
            5'd14: step_o = wr(8'h2E, 8'h01);
            5'd15: step_o = wr(8'h02, 8'h00);
            // analogue off
            5'd17: step_o = wr(8'h02, 8'h10);
            5'd18: step_o = PAUSE_STEP;
            5'd19: step_o = wr(8'h2E, 8'h00);
            5'd20: step_o = wr(8'h02, 8'h00);
            default: step_o = wr(TABLE_END, 8'h00);
        endcase
    end

endmodule

// File: rtl/dacctl_pause.sv
module dacctl_pause #(
    parameter int unsigned TICKS = 5000000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic done_o
);

    localparam int CNT_W = $clog2(TICKS + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = CNT_W'(TICKS);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dacctl_xfer.sv
module dacctl_xfer
    import dacctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       probe_i,
    input  logic [7:0] dev_i,
    input  logic [7:0] ridx_i,
    input  logic [7:0] val_i,
    output logic       op_valid_o,
    output logic [1:0] op_kind_o,
    output logic [7:0] op_byte_o,
    input  logic       op_done_i,
    input  logic       op_nack_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       nacked_o
);

    typedef struct packed {
        logic       active;
        logic       probe;
        logic [2:0] step;
        logic       nacked;
        logic [7:0] dev;
        logic [7:0] ridx;
        logic [7:0] val;
    } xfer_t;

    xfer_t   d, q;
    i2c_op_e cur_kind;
    logic [7:0] cur_byte;
    logic [2:0] stop_step;

    always_comb begin
        cur_kind = OP_STOP;
        cur_byte = 8'h00;
        if (q.probe) begin
            case (q.step)
                3'd0: cur_kind = OP_START;
                3'd1: begin cur_kind = OP_WRITE; cur_byte = {q.dev[7:1], 1'b0}; end
                3'd2: begin cur_kind = OP_WRITE; cur_byte = 8'h00; end
                3'd3: cur_kind = OP_START;
                3'd4: begin cur_kind = OP_WRITE; cur_byte = {q.dev[7:1], 1'b1}; end
                3'd5: cur_kind = OP_READ;
                default: cur_kind = OP_STOP;
            endcase
        end else begin
            case (q.step)
                3'd0: cur_kind = OP_START;
                3'd1: begin cur_kind = OP_WRITE; cur_byte = {q.dev[7:1], 1'b0}; end
                3'd2: begin cur_kind = OP_WRITE; cur_byte = q.ridx; end
                3'd3: begin cur_kind = OP_WRITE; cur_byte = q.val; end
                default: cur_kind = OP_STOP;
            endcase
        end
        stop_step = q.probe ? 3'd6 : 3'd4;

        d = q;
        if (!q.active) begin
            if (start_i) begin
                d.active = 1'b1;
                d.probe  = probe_i;
                d.step   = 3'd0;
                d.nacked = 1'b0;
                d.dev    = dev_i;
                d.ridx   = ridx_i;
                d.val    = val_i;
            end
        end else if (op_done_i) begin
            if (cur_kind == OP_STOP) begin
                d.active = 1'b0;
            end else if (cur_kind == OP_WRITE && op_nack_i) begin
                d.step   = stop_step;
                d.nacked = 1'b1;
            end else begin
                d.step = q.step + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign op_valid_o = q.active;
    assign op_kind_o  = cur_kind;
    assign op_byte_o  = cur_byte;
    assign busy_o     = q.active;
    assign done_o     = q.active && op_done_i && (cur_kind == OP_STOP);
    assign nacked_o   = q.nacked;

endmodule

// File: rtl/dacctl_seq.sv
module dacctl_seq
    import dacctl_pkg::*;
#(
    parameter int unsigned CYC_PER_MS  = 100000,
    parameter int unsigned PAUSE_MS    = 50,
    parameter logic [7:0]  ADDR_FIRST  = 8'h90,
    parameter logic [7:0]  ADDR_SECOND = 8'h98
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CMDS-1:0] cmd_req_i,
    output logic                cmd_ack_o,
    output logic                busy_o,
    output logic                error_o,
    output logic [7:0]          dev_addr_o,
    output logic                i2c_op_valid_o,
    output logic [1:0]          i2c_op_o,
    output logic [7:0]          i2c_byte_o,
    input  logic                i2c_done_i,
    input  logic                i2c_nack_i
);

    localparam int unsigned PAUSE_TICKS = CYC_PER_MS * PAUSE_MS;

    typedef struct packed {
        seq_state_e       state;
        logic [PTR_W-1:0] ptr;
        logic             pidx;
        logic [7:0]       dev;
        logic             err;
        logic             ack;
    } seq_t;

    seq_t d, q;

    seq_step_t        step;
    logic             step_end;
    logic             x_start, x_probe, x_busy, x_done, x_nacked;
    logic [7:0]       x_dev, cand;
    logic             tmr_load, tmr_done;
    logic             req_ok;
    logic [PTR_W-1:0] sel_base;

    dacctl_script u_script (
        .ptr_i  (q.ptr),
        .step_o (step)
    );

    dacctl_xfer u_xfer (
        .clk        (clk),
        .rst        (rst),
        .start_i    (x_start),
        .probe_i    (x_probe),
        .dev_i      (x_dev),
        .ridx_i     (step.ridx),
        .val_i      (step.val),
        .op_valid_o (i2c_op_valid_o),
        .op_kind_o  (i2c_op_o),
        .op_byte_o  (i2c_byte_o),
        .op_done_i  (i2c_done_i),
        .op_nack_i  (i2c_nack_i),
        .busy_o     (x_busy),
        .done_o     (x_done),
        .nacked_o   (x_nacked)
    );

    dacctl_pause #(.TICKS(PAUSE_TICKS)) u_pause (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .done_o (tmr_done)
    );

    assign step_end = !step.pause && (step.ridx == TABLE_END);
    assign req_ok   = (cmd_req_i != '0) &&
                      ((cmd_req_i & (cmd_req_i - 1'b1)) == '0);

    always_comb begin
        sel_base = '0;
        for (int i = 0; i < NUM_CMDS; i++)
            if (cmd_req_i[i]) sel_base = cmd_entry(i);
    end

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        cand     = q.pidx ? ADDR_SECOND : ADDR_FIRST;
        x_start  = 1'b0;
        x_probe  = 1'b0;
        x_dev    = q.dev;
        tmr_load = 1'b0;
        case (q.state)
            SQ_PROBE: begin
                x_probe = 1'b1;
                x_dev   = cand;
                x_start = !x_busy;
                if (x_done) begin
                    if (!x_nacked) begin
                        d.dev   = cand;
                        d.ptr   = '0;
                        d.state = SQ_RUN;
                    end else if (!q.pidx) begin
                        d.pidx = 1'b1;
                    end else begin
                        d.err   = 1'b1;
                        d.state = SQ_IDLE;
                    end
                end
            end
            SQ_RUN: begin
                if (x_done) begin
                    d.err = q.err | x_nacked;
                    d.ptr = q.ptr + 1'b1;
                end else if (!x_busy) begin
                    if (step_end) begin
                        d.state = SQ_IDLE;
                    end else if (step.pause) begin
                        tmr_load = 1'b1;
                        d.state  = SQ_WAIT;
                    end else begin
                        x_start = 1'b1;
                    end
                end
            end
            SQ_WAIT: begin
                if (tmr_done) begin
                    d.ptr   = q.ptr + 1'b1;
                    d.state = SQ_RUN;
                end
            end
            default: begin
                if (req_ok) begin
                    d.ack   = 1'b1;
                    d.ptr   = sel_base;
                    d.state = SQ_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state <= SQ_PROBE;
            q.ptr   <= '0;
            q.pidx  <= 1'b0;
            q.dev   <= 8'h00;
            q.err   <= 1'b0;
            q.ack   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ack_o  = q.ack;
    assign busy_o     = (q.state != SQ_IDLE);
    assign error_o    = q.err;
    assign dev_addr_o = q.dev;

endmodule

// File: rtl/dacctl_seq_chk.sv
module dacctl_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] cmd_req_i,
    input logic       cmd_ack_o,
    input logic       busy_o,
    input logic       error_o,
    input logic [7:0] dev_addr_o,
    input logic       i2c_op_valid_o,
    input logic [1:0] i2c_op_o,
    input logic [7:0] i2c_byte_o,
    input logic       i2c_done_i
);

    p_hold_op_r10: assert property (@(posedge clk) disable iff (rst)
        (i2c_op_valid_o && !i2c_done_i) |=>
            (i2c_op_valid_o && $stable(i2c_op_o) && $stable(i2c_byte_o)));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        error_o |=> error_o);

    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_ack_o |=> !cmd_ack_o);

    p_ack_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_ack_o |-> $onehot($past(cmd_req_i)));

    p_ack_busy_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_ack_o |-> busy_o);

    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !i2c_op_valid_o);

    p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(dev_addr_o));

endmodule

bind dacctl_seq dacctl_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_req_i      (cmd_req_i),
    .cmd_ack_o      (cmd_ack_o),
    .busy_o         (busy_o),
    .error_o        (error_o),
    .dev_addr_o     (dev_addr_o),
    .i2c_op_valid_o (i2c_op_valid_o),
    .i2c_op_o       (i2c_op_o),
    .i2c_byte_o     (i2c_byte_o),
    .i2c_done_i     (i2c_done_i)
);

// File: tb/dacctl_seq_test.sv
module dacctl_seq_test;

    localparam int CPM   = 20;
    localparam int PMS   = 50;
    localparam int TICKS = CPM * PMS;
    localparam int LAT   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] req = '0;
    logic       ack, busy, err, op_valid;
    logic [7:0] addr, op_byte;
    logic [1:0] op_kind;
    logic       done_drv = 1'b0;
    logic       nack_drv = 1'b0;

    always #2 clk = ~clk;

    dacctl_seq #(.CYC_PER_MS(CPM), .PAUSE_MS(PMS)) uut (
        .clk            (clk),
        .rst            (rst),
        .cmd_req_i      (req),
        .cmd_ack_o      (ack),
        .busy_o         (busy),
        .error_o        (err),
        .dev_addr_o     (addr),
        .i2c_op_valid_o (op_valid),
        .i2c_op_o       (op_kind),
        .i2c_byte_o     (op_byte),
        .i2c_done_i     (done_drv),
        .i2c_nack_i     (nack_drv)
    );

    typedef struct {
        int         kind;
        logic [7:0] b;
        bit         err;
        int         boff;
        bit         aset;
        logic [7:0] aval;
        bit         ap;
        string      tag;
    } exp_op_t;

    exp_op_t    eq[$];
    int         n_cmp = 0, n_bad = 0, cyc = 0;
    bit         exp_busy, exp_err;
    logic [7:0] exp_addr, addr_nxt, cur_addr;
    int         ack_at = -1, busy_on_at = -1, busy_off_at = -1, err_at = -1, addr_at = -1;
    bit         dev_on;
    logic [7:0] dev, bad_reg;
    int         lat = 0, wcnt = 0, last_stop = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    function automatic bit acks(input logic [7:0] a);
        return dev_on && (a[7:1] == dev[7:1]);
    endfunction

    task automatic add(input int kind, input logic [7:0] b, input string tag,
                       input bit e = 0, input int boff = 0, input bit aset = 0,
                       input logic [7:0] aval = 8'h00, input bit ap = 0);
        exp_op_t x;
        x.kind = kind; x.b = b; x.err = e; x.boff = boff;
        x.aset = aset; x.aval = aval; x.ap = ap; x.tag = tag;
        eq.push_back(x);
    endtask

    // R3 / R9: one register write transaction with abort on refused byte
    task automatic model_write(input logic [7:0] a, input logic [7:0] r, input logic [7:0] v,
                               input bit last, input bit ap, input string tag);
        add(0, 8'h00, tag, 0, 0, 0, 8'h00, ap);
        add(1, {a[7:1], 1'b0}, tag);
        if (!acks(a)) begin add(3, 8'h00, "R9", 1, last ? 2 : 0); return; end
        add(1, r, tag);
        if (r == bad_reg) begin add(3, 8'h00, "R9", 1, last ? 2 : 0); return; end
        add(1, v, tag);
        add(3, 8'h00, tag, 0, last ? 2 : 0);
    endtask

    // R1 / R2: probe of one candidate address
    task automatic model_probe(input logic [7:0] a, input bit final_try);
        add(0, 8'h00, "R1");
        add(1, {a[7:1], 1'b0}, "R1");
        if (!acks(a)) begin add(3, 8'h00, "R2", final_try, final_try ? 1 : 0); return; end
        add(1, 8'h00, "R1");
        add(0, 8'h00, "R1");
        add(1, {a[7:1], 1'b1}, "R1");
        add(2, 8'h00, "R1");
        add(3, 8'h00, "R1", 0, 0, 1, a);
    endtask

    task automatic model_init(input logic [7:0] a);
        model_write(a, 8'h00, 8'h00, 0, 0, "R4");
        model_write(a, 8'h02, 8'h10, 0, 0, "R4");
        model_write(a, 8'h0D, 8'h10, 0, 0, "R4");
        model_write(a, 8'h25, 8'h08, 0, 0, "R4");
        model_write(a, 8'h02, 8'h00, 1, 0, "R4");
    endtask

    task automatic model_cmd(input int i);
        case (i)
            0: model_write(cur_addr, 8'h02, 8'h00, 1, 0, "R5");
            1: model_write(cur_addr, 8'h02, 8'h10, 1, 0, "R5");
            2: model_write(cur_addr, 8'h02, 8'h01, 1, 0, "R5");
            default: begin
                model_write(cur_addr, 8'h02, 8'h10, 0, 0, "R6");
                model_write(cur_addr, 8'h2E, (i == 3) ? 8'h01 : 8'h00, 0, 1, "R6");
                model_write(cur_addr, 8'h02, 8'h00, 1, 0, "R6");
            end
        endcase
    endtask

    task automatic serve();
        exp_op_t e;
        bit nk;
        nk = 1'b0;
        if (eq.size() == 0) begin
            chk(0, "R7", "unexpected bus operation", int'(op_kind), -1);
            done_drv = 1'b1; nack_drv = 1'b0;
            return;
        end
        e = eq.pop_front();
        chk(int'(op_kind) == e.kind, e.tag, "operation code (R10)", int'(op_kind), e.kind);
        if (e.kind == 1)
            chk(op_byte == e.b, e.tag, "written byte", int'(op_byte), int'(e.b));
        if (op_kind == 2'd0) wcnt = 0;
        if (op_kind == 2'd1) begin
            wcnt++;
            nk = (wcnt == 1 && !acks(op_byte)) || (wcnt == 2 && op_byte == bad_reg);
        end
        if (op_kind == 2'd3) begin
            last_stop = cyc;
            if (e.err) err_at = cyc + 1;
            if (e.boff != 0) busy_off_at = cyc + e.boff;
            if (e.aset) begin addr_at = cyc + 1; addr_nxt = e.aval; end
        end
        done_drv = 1'b1;
        nack_drv = nk;
    endtask

    // One clock: model update, comparison of every output, device responder
    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc == busy_on_at)  exp_busy = 1'b1;
        if (cyc == busy_off_at) exp_busy = 1'b0;
        if (cyc == err_at)      exp_err  = 1'b1;
        if (cyc == addr_at)     exp_addr = addr_nxt;
        chk(busy == exp_busy, "R8", "busy", int'(busy), int'(exp_busy));
        chk(err == exp_err, "R9", "error flag", int'(err), int'(exp_err));
        chk(addr == exp_addr, "R1", "device address", int'(addr), int'(exp_addr));
        chk(ack == (cyc == ack_at), "R7", "ack", int'(ack), int'(cyc == ack_at));
        if (rst) begin
            chk(!op_valid, "R11", "op valid in reset", int'(op_valid), 0);
            done_drv = 1'b0; nack_drv = 1'b0; lat = 0;
        end else if (done_drv) begin
            done_drv = 1'b0; nack_drv = 1'b0;
        end else if (op_valid) begin
            if (lat == 0 && eq.size() > 0 && eq[0].ap)
                chk((cyc - last_stop) >= TICKS && (cyc - last_stop) <= TICKS + 4,
                    "R6", "pause length", cyc - last_stop, TICKS);
            if (lat == LAT - 1) begin lat = 0; serve(); end
            else lat++;
        end
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        do begin step(); t++; end
        while ((eq.size() != 0 || busy || done_drv) && t < 20000);
        chk(t < 20000, "R8", "sequence completion", t, 20000);
        repeat (3) step();
    endtask

    task automatic issue(input int i);
        req = 5'(1 << i);
        model_cmd(i);
        ack_at = cyc + 1;
        busy_on_at = cyc + 1;
        step();
        req = '0;
    endtask

    task automatic do_reset(input bit on, input logic [7:0] a);
        rst = 1'b1;
        req = '0;
        eq.delete();
        dev_on = on; dev = a; bad_reg = 8'hEE;
        exp_busy = 1'b1; exp_err = 1'b0; exp_addr = 8'h00;
        ack_at = -1; busy_on_at = -1; busy_off_at = -1; err_at = -1; addr_at = -1;
        repeat (3) step();
        chk(busy && !err && !ack && addr == 8'h00, "R11", "reset state",
            {busy, err, ack, |addr}, 4'b1000);
        cur_addr = 8'h00;
        model_probe(8'h90, 0);
        if (acks(8'h90)) begin
            cur_addr = 8'h90; model_init(8'h90);
        end else begin
            model_probe(8'h98, 1);
            if (acks(8'h98)) begin cur_addr = 8'h98; model_init(8'h98); end
        end
        rst = 1'b0;
    endtask

    initial begin
        // device at the second address: probe falls through
        do_reset(1, 8'h98);
        wait_idle();
        chk(addr == 8'h98, "R1", "second address latched", int'(addr), 8'h98);
        chk(err == 1'b0, "R4", "clean start-up", int'(err), 0);

        for (int i = 0; i < 5; i++) begin
            issue(i);
            wait_idle();
        end

        // several request bits together: ignored
        req = 5'b00011;
        repeat (4) step();
        req = '0;
        step();
        chk(busy == 1'b0, "R7", "multi-bit request ignored", int'(busy), 0);

        // request raised while busy: ignored
        issue(1);
        req = 5'b00100;
        repeat (2) step();
        req = '0;
        wait_idle();
        chk(eq.size() == 0, "R7", "busy request produced no ops", eq.size(), 0);

        // refused register inside a compound command
        bad_reg = 8'h2E;
        issue(4);
        wait_idle();
        chk(err == 1'b1, "R9", "error after refused byte", int'(err), 1);
        bad_reg = 8'hEE;
        issue(0);
        wait_idle();
        chk(err == 1'b1, "R9", "error stays set", int'(err), 1);

        // device at the first address: only one probe
        do_reset(1, 8'h90);
        wait_idle();
        chk(addr == 8'h90, "R1", "first address latched", int'(addr), 8'h90);
        issue(3);
        wait_idle();

        // no device
        do_reset(0, 8'h00);
        wait_idle();
        chk(addr == 8'h00 && err == 1'b1, "R2", "no device found",
            {addr, err}, 9'h001);
        issue(2);
        wait_idle();
        chk(err == 1'b1, "R9", "error after unanswered command", int'(err), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule